// File: doc/BRIEF.md
# Debug Bank Multiplexer

This block lets a large number of internal signals be watched through a small group of debug pins. The internal signals are grouped into banks of identical width; at any moment one bank is routed to the pins. Which bank is routed is held in a small control register that a simple write port updates while the chip runs. That port stands in for whatever serial control path sits in front of it.

The bank count, the bank width and the time-division option are fixed when the block is built. With time division off, the block has one pin per bank signal and refreshes every pin each cycle. With time division on, each pin carries two signals of the bank on alternate cycles, so half as many pins are needed. The first cycle of a frame carries the lower half of the bank and the second cycle carries the upper half. A phase output is high on the lower-half cycle, so an external analyzer can put the pairs back together.

A newly written bank number only takes effect between frames, so the two halves shown in one frame always come from the same bank. Bank numbers beyond the configured bank count are dropped.

Top module: `dbg_bank_mux`

## Requirements
- R1: While reset is asserted, the pins and the phase output are 0. After reset, bank 0 is selected, and the first output word after reset is a slot-0 (lower half) word.
- R2: With time division off, the pins equal the selected bank's signals as sampled at the previous rising clock edge. Bank b occupies bits [b*BANK_W +: BANK_W] of the bank bus.
- R3: An in-range select write (value < NUM_BANKS) is recorded at the edge that samples it. With time division off, the new bank's data first reaches the pins at the third rising edge, counting that recording edge as the first.
- R4: A select write with a value of NUM_BANKS or more leaves the selection unchanged, and the pins keep showing the previously selected bank.
- R5: With time division on, the pins carry bits [PIN_W-1:0] of the selected bank in slot 0 and bits [BANK_W-1:PIN_W] in slot 1, where PIN_W = BANK_W/2. Slot 0 and slot 1 alternate on every clock.
- R6: The phase output is 1 on slot-0 words and 0 on slot-1 words, so it toggles every clock. With time division off, it stays 1 from the first edge after reset.
- R7: With time division on, a recorded select moves into the active register only at an edge that ends a slot-1 cycle. Both words of any frame therefore come from one bank, and the new bank appears in the first frame that starts after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_bus | input | NUM_BANKS*BANK_W | All banks packed together; bank b at [b*BANK_W +: BANK_W] |
| sel_wr_en | input | 1 | Write strobe for the bank select register |
| sel_wr_data | input | CTRL_W | Requested bank number |
| dbg_pins | output | BANK_W/2 when time division is on, else BANK_W | Registered debug pin word |
| dbg_phase | output | 1 | 1 on a slot-0 (lower half) word, 0 on a slot-1 word |

## Verification
Each state register in the block shows up at the pins quickly if it is wrong.

- **Active bank register:** a bad value puts a different bank's pattern on the pins at the very next edge, because every bank carries a distinct pattern.
- **Slot register:** a bad value either breaks the phase alternation on the next word or pairs a phase value with the wrong half of the bank.
- **Pending select register:** an error stays hidden until the next frame boundary loads it, so the bench follows every write through the full three-to-four-edge window to the pins.
- **Dropped writes:** that ignored writes really are dropped is confirmed by watching the old bank persist for several frames afterwards.

// File: rtl/dbg_mux_pkg.sv
package dbg_mux_pkg;

   typedef enum logic {
      SLOT_LO = 1'b0,
      SLOT_HI = 1'b1
   } slot_t;

   function automatic bit is_legal_bank_count(input int n);
      return (n == 2) || (n == 4) || (n == 8) || (n == 16) || (n == 32);
   endfunction

   function automatic bit is_legal_bank_width(input int w);
      return (w >= 4) && (w <= 128);
   endfunction

endpackage

// File: rtl/dbg_sel_ctrl.sv
module dbg_sel_ctrl
   import dbg_mux_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int CTRL_W    = 8,
   parameter int SEL_W     = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              load,
   output logic [SEL_W-1:0]  pend_sel,
   output logic [SEL_W-1:0]  act_sel
);

   localparam logic [32:0] BANK_LIMIT = 33'(NUM_BANKS);

   logic wr_legal;

   // Compare in a width that holds both the request and the bank count.
   assign wr_legal = wr_en && (33'(wr_data) < BANK_LIMIT);

   // Staging register: written by the control port, out-of-range values dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_sel <= '0;
      end else if (wr_legal) begin
         pend_sel <= wr_data[SEL_W-1:0];
      end
   end

   // Active register: updated only at frame boundaries.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= '0;
      end else if (load) begin
         act_sel <= pend_sel;
      end
   end

endmodule

// File: rtl/dbg_slot_gen.sv
module dbg_slot_gen
   import dbg_mux_pkg::*;
#(
   parameter bit TDM_EN = 1'b1
)(
   input  logic  clk,
   input  logic  rst_n,
   output slot_t slot,
   output logic  frame_end
);

   slot_t slot_q;

   generate
      if (TDM_EN) begin : g_two_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= SLOT_LO;
            end else begin
               slot_q <= (slot_q == SLOT_LO) ? SLOT_HI : SLOT_LO;
            end
         end
         assign frame_end = (slot_q == SLOT_HI);
      end else begin : g_one_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= SLOT_LO;
            end else begin
               slot_q <= SLOT_LO;
            end
         end
         assign frame_end = 1'b1;
      end
   endgenerate

   assign slot = slot_q;

endmodule

// File: rtl/dbg_bank_pick.sv
module dbg_bank_pick #(
   parameter int NUM_BANKS = 8,
   parameter int BANK_W    = 16,
   parameter int SEL_W     = 3
)(
   input  logic [NUM_BANKS*BANK_W-1:0] bank_bus,
   input  logic [SEL_W-1:0]            sel,
   output logic [BANK_W-1:0]           word
);

   logic [BANK_W-1:0] bank_arr [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
         assign bank_arr[b] = bank_bus[b*BANK_W +: BANK_W];
      end
   endgenerate

   assign word = bank_arr[sel];

endmodule

// File: rtl/dbg_tdm_ser.sv
module dbg_tdm_ser
   import dbg_mux_pkg::*;
#(
   parameter int BANK_W = 16,
   parameter int PIN_W  = 8,
   parameter bit TDM_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] word,
   input  slot_t             slot,
   output logic [PIN_W-1:0]  pins,
   output logic              phase
);

   logic [PIN_W-1:0] pins_d;

   generate
      if (TDM_EN) begin : g_split
         assign pins_d = (slot == SLOT_HI) ? word[BANK_W-1:PIN_W] : word[PIN_W-1:0];
      end else begin : g_full
         assign pins_d = word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins  <= '0;
         phase <= 1'b0;
      end else begin
         pins  <= pins_d;
         phase <= (slot == SLOT_LO);
      end
   end

endmodule

// File: rtl/dbg_bank_mux.sv
module dbg_bank_mux
   import dbg_mux_pkg::*;
#(
   parameter int  NUM_BANKS = 8,
   parameter int  BANK_W    = 16,
   parameter bit  TDM_EN    = 1'b1,
   parameter int  CTRL_W    = 8,
   localparam int SEL_W     = $clog2(NUM_BANKS),
   localparam int PIN_W     = TDM_EN ? BANK_W / 2 : BANK_W
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] bank_bus,
   input  logic                        sel_wr_en,
   input  logic [CTRL_W-1:0]           sel_wr_data,
   output logic [PIN_W-1:0]            dbg_pins,
   output logic                        dbg_phase
);

   generate
      if (!is_legal_bank_count(NUM_BANKS)) begin : g_bad_count
         $error("dbg_bank_mux: NUM_BANKS must be 2, 4, 8, 16 or 32");
      end
      if (!is_legal_bank_width(BANK_W)) begin : g_bad_width
         $error("dbg_bank_mux: BANK_W must lie in 4..128");
      end
      if (TDM_EN && (BANK_W % 2 != 0)) begin : g_odd_width
         $error("dbg_bank_mux: time division needs an even BANK_W");
      end
      if ((CTRL_W < SEL_W) || (CTRL_W > 32)) begin : g_bad_ctrl
         $error("dbg_bank_mux: CTRL_W must cover the select and be at most 32");
      end
   endgenerate

   logic [SEL_W-1:0]  pend_sel;
   logic [SEL_W-1:0]  act_sel;
   slot_t             slot;
   logic              frame_end;
   logic [BANK_W-1:0] picked;

   dbg_slot_gen #(
      .TDM_EN (TDM_EN)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (slot),
      .frame_end (frame_end)
   );

   dbg_sel_ctrl #(
      .NUM_BANKS (NUM_BANKS),
      .CTRL_W    (CTRL_W),
      .SEL_W     (SEL_W)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_wr_en),
      .wr_data  (sel_wr_data),
      .load     (frame_end),
      .pend_sel (pend_sel),
      .act_sel  (act_sel)
   );

   dbg_bank_pick #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .SEL_W     (SEL_W)
   ) u_pick (
      .bank_bus (bank_bus),
      .sel      (act_sel),
      .word     (picked)
   );

   dbg_tdm_ser #(
      .BANK_W (BANK_W),
      .PIN_W  (PIN_W),
      .TDM_EN (TDM_EN)
   ) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (picked),
      .slot  (slot),
      .pins  (dbg_pins),
      .phase (dbg_phase)
   );

endmodule

// File: rtl/dbg_bank_mux_chk.sv
module dbg_bank_mux_chk #(
   parameter int NUM_BANKS = 8,
   parameter bit TDM_EN    = 1'b1,
   parameter int CTRL_W    = 8,
   parameter int SEL_W     = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CTRL_W-1:0] wr_data,
   input logic [SEL_W-1:0]  pend_sel,
   input logic [SEL_W-1:0]  act_sel,
   input logic              frame_end,
   input logic              phase
);

   logic started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   assert_good_write_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (33'(wr_data) < 33'(NUM_BANKS))) |=> (pend_sel == SEL_W'($past(wr_data))));

   assert_bad_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (33'(wr_data) >= 33'(NUM_BANKS))) |=> $stable(pend_sel));

   assert_hold_mid_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(act_sel));

   assert_load_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (act_sel == $past(pend_sel)));

   assert_phase_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
      started |=> (TDM_EN ? (phase != $past(phase)) : phase));

endmodule

bind dbg_bank_mux dbg_bank_mux_chk #(
   .NUM_BANKS (NUM_BANKS),
   .TDM_EN    (TDM_EN),
   .CTRL_W    (CTRL_W),
   .SEL_W     (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (sel_wr_en),
   .wr_data   (sel_wr_data),
   .pend_sel  (pend_sel),
   .act_sel   (act_sel),
   .frame_end (frame_end),
   .phase     (dbg_phase)
);

// File: tb/sim_dbg_bank_mux.sv
module sim_dbg_bank_mux;

   localparam int NB = 4;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB*BW-1:0] banks = '0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [BW-1:0] pins_full;
   logic          phase_full;
   logic [BW/2-1:0] pins_tdm;
   logic          phase_tdm;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dbg_bank_mux #(.NUM_BANKS(NB), .BANK_W(BW), .TDM_EN(1'b0), .CTRL_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bank_bus(banks), .sel_wr_en(wr_en),
      .sel_wr_data(wr_data), .dbg_pins(pins_full), .dbg_phase(phase_full));

   dbg_bank_mux #(.NUM_BANKS(NB), .BANK_W(BW), .TDM_EN(1'b1), .CTRL_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .bank_bus(banks), .sel_wr_en(wr_en),
      .sel_wr_data(wr_data), .dbg_pins(pins_tdm), .dbg_phase(phase_tdm));

   function automatic logic [7:0] pat(input int b, input int s);
      return 8'(b * 8'h35 + s * 8'h1B + 8'h5A);
   endfunction

   function automatic logic [BW-1:0] bank_of(input int b);
      return banks[b*BW +: BW];
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_pattern(input int s);
      for (int b = 0; b < NB; b++) banks[b*BW +: BW] = pat(b, s);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_tdm(input string req, input int b, input logic want_phase);
      logic [BW-1:0] w;
      w = bank_of(b);
      chk({req, " phase"}, 32'(phase_tdm), 32'(want_phase));
      chk({req, " pins"}, 32'(pins_tdm), want_phase ? 32'(w[BW/2-1:0]) : 32'(w[BW-1:BW/2]));
   endtask

   task automatic write_sel(input logic [7:0] v);
      wr_en = 1'b1;
      wr_data = v;
      step();
      wr_en = 1'b0;
   endtask

   task automatic test_reset();
      set_pattern(0);
      step(); step();
      chk("R1 reset pins full", 32'(pins_full), 0);
      chk("R1 reset phase full", 32'(phase_full), 0);
      chk("R1 reset pins tdm", 32'(pins_tdm), 0);
      chk("R1 reset phase tdm", 32'(phase_tdm), 0);
      rst_n = 1'b1;
      step();
      chk("R1 bank0 after reset", 32'(pins_full), 32'(bank_of(0)));
      chk_tdm("R1 first word slot0", 0, 1'b1);
      step();
      chk_tdm("R1 second word slot1", 0, 1'b0);
   endtask

   task automatic test_passthrough();
      for (int s = 1; s <= 3; s++) begin
         set_pattern(s);
         step();
         chk("R2 full pins follow bank0", 32'(pins_full), 32'(bank_of(0)));
         chk("R6 full phase high", 32'(phase_full), 1);
      end
   endtask

   task automatic test_select();
      write_sel(8'd2);
      chk("R3 old bank after write edge", 32'(pins_full), 32'(bank_of(0)));
      step();
      chk("R3 old bank second edge", 32'(pins_full), 32'(bank_of(0)));
      step();
      chk("R3 bank2 third edge", 32'(pins_full), 32'(bank_of(2)));
      write_sel(8'd3);
      step(); step();
      chk("R3 bank3 third edge", 32'(pins_full), 32'(bank_of(3)));
   endtask

   task automatic test_ignore();
      write_sel(8'd4);
      write_sel(8'd255);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R4 full still bank3", 32'(pins_full), 32'(bank_of(3)));
      end
      step();
      chk_tdm("R4 tdm still bank3", 3, phase_tdm);
      step();
      chk_tdm("R4 tdm still bank3 next", 3, phase_tdm);
   endtask

   task automatic test_tdm_alt();
      logic prev;
      prev = phase_tdm;
      for (int i = 0; i < 6; i++) begin
         step();
         chk_tdm("R5 R6 alternating halves", 3, ~prev);
         prev = ~prev;
      end
   endtask

   task automatic test_tdm_switch();
      for (int i = 0; i < 3 && phase_tdm !== 1'b1; i++) step();
      // slot register now at slot 1: write edge closes a frame
      write_sel(8'd1);
      chk_tdm("R7 a e0 old upper", 3, 1'b0);
      step(); chk_tdm("R7 a e1 old lower", 3, 1'b1);
      step(); chk_tdm("R7 a e2 old upper", 3, 1'b0);
      step(); chk_tdm("R7 a e3 new lower", 1, 1'b1);
      step(); chk_tdm("R7 a e4 new upper", 1, 1'b0);
      // slot register now at slot 0: write lands mid frame
      write_sel(8'd0);
      chk_tdm("R7 b e0 old lower", 1, 1'b1);
      step(); chk_tdm("R7 b e1 old upper", 1, 1'b0);
      step(); chk_tdm("R7 b e2 new lower", 0, 1'b1);
      step(); chk_tdm("R7 b e3 new upper", 0, 1'b0);
   endtask

   initial begin
      test_reset();
      test_passthrough();
      test_select();
      test_ignore();
      test_tdm_alt();
      test_tdm_switch();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule